// File: doc/BRIEF.md
# Video Memory Access-Code Port

This block serves the host data port of a tile-based display processor. A command loads a 4-bit access code and a 16-bit address, and the block holds both. Each later data-port write or read is routed by the held code to video RAM, colour RAM or vertical-scroll RAM. After each access the held address steps by a host-supplied increment.

The block models the write queue as one register holding the most recent data-port write. Any read bit that the selected memory does not drive is taken from that register. A 16-bit video RAM read waits for a free external access slot, which occurs once every 16 clocks in wide mode and once every 20 clocks in narrow mode. Every other read completes in the cycle it is requested. A byte-wide video RAM read is available on the opposite byte lane. Codes that the hardware treats as register writes, and codes with undefined behaviour, have no effect on memory.

Top module: `vdp_data_port`

## Requirements
- R1: Reset clears the held address, the held code and the last-write value to zero, and rd_ready_o is low. A cmd_valid_i cycle loads cmd_code_i and cmd_addr_i.
- R2: Code 1 is a video RAM word write. wr_data_i[15:8] goes to the even byte and wr_data_i[7:0] to the odd byte of the word at address bits [VRAM_AW-1:1]. Code 0 is a word read that returns {even byte, odd byte} of that word.
- R3: A code 0 read is accepted only in a slot cycle. Slot cycles recur every 16 clocks while wide_mode_i is 1 and every 20 clocks while it is 0.
- R4: Code 0xC is a byte read, accepted at once. Bits [7:0] hold the byte at the held address with bit 0 inverted. Bits [15:8] hold the last-write value's bits [15:8].
- R5: Code 3 is a colour write. It keeps only the data bits under mask 0x0EEE, in the entry indexed by address bits [6:1], so the index wraps modulo 64. Code 8 reads that entry back on the masked bits, and every other bit comes from the last-write value.
- R6: Code 5 writes bits [10:0] to vertical-scroll entry address[6:1] when that index is below 40, and code 4 reads it back. Bits [15:11] come from the last-write value. For an index of 40 or more, the write is dropped and the read returns the whole last-write value.
- R7: Codes 2, 6, 0xA and 0xE (low bits 10), and codes 7, 9, 0xB, 0xD and 0xF, are no-ops. Their reads are accepted at once and return the last-write value. Writes under these codes, or under a read code, change no memory.
- R8: Every data-port write, and every accepted read, adds incr_i to the held address modulo 2^16.
- R9: Every data-port write stores wr_data_i as the last-write value, whatever the held code.
- R10: rd_ready_o stays low in any cycle in which cmd_valid_i or wr_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_mode_i | input | 1 | 1 selects the 16-clock slot period, 0 the 20-clock period |
| cmd_valid_i | input | 1 | Load code and address |
| cmd_code_i | input | 4 | Access code |
| cmd_addr_i | input | 16 | Start address |
| incr_i | input | 8 | Address step per access |
| wr_valid_i | input | 1 | Data-port write strobe |
| wr_data_i | input | 16 | Data-port write value |
| rd_valid_i | input | 1 | Read request, held until accepted |
| rd_ready_o | output | 1 | Read accepted this cycle |
| rd_data_o | output | 16 | Read data, valid while rd_ready_o is high |

## Verification
The bench builds the block with VRAM_AW = 8 and leaves every other parameter at its default. With 256 bytes of video RAM, word and byte sweeps cover every video RAM location. At the default depths, incrementing sweeps reach all 64 colour entries and all 40 vertical-scroll entries, plus the 24 indices that fall beyond the vertical-scroll depth. The slot spacing is measured between back-to-back word reads in both modes.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_REG,
    OP_VRAM_RD16,
    OP_VRAM_RD8,
    OP_VRAM_WR,
    OP_CRAM_RD,
    OP_CRAM_WR,
    OP_VS_RD,
    OP_VS_WR
  } op_e;

  localparam logic [15:0] CRAM_MASK = 16'h0EEE;
  localparam int CRAM_DW = 9;

  function automatic logic [CRAM_DW-1:0] cram_pack(input logic [15:0] d);
    return {d[11:9], d[7:5], d[3:1]};
  endfunction

  function automatic logic [15:0] cram_unpack(input logic [CRAM_DW-1:0] c);
    return {4'b0, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
  endfunction

endpackage

// File: rtl/dp_code_dec.sv
module dp_code_dec
  import vdp_port_pkg::*;
(
  input  logic [3:0] code_i,
  output op_e        op_o
);
  always_comb begin
    unique case (code_i)
      4'h0:                      op_o = OP_VRAM_RD16;
      4'h1:                      op_o = OP_VRAM_WR;
      4'h3:                      op_o = OP_CRAM_WR;
      4'h4:                      op_o = OP_VS_RD;
      4'h5:                      op_o = OP_VS_WR;
      4'h8:                      op_o = OP_CRAM_RD;
      4'hC:                      op_o = OP_VRAM_RD8;
      4'h2, 4'h6, 4'hA, 4'hE:    op_o = OP_REG;  // decoded as register write upstream
      default:                   op_o = OP_NOP;
    endcase
  end
endmodule

// File: rtl/dp_slot_timer.sv
module dp_slot_timer #(
  parameter int WIDE   = 16,
  parameter int NARROW = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wide_i,
  output logic slot_o
);
  localparam int MAXP = (WIDE > NARROW) ? WIDE : NARROW;
  localparam int CW   = (MAXP > 1) ? $clog2(MAXP) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = wide_i ? CW'(WIDE - 1) : CW'(NARROW - 1);
  assign slot_o = (cnt_q >= lim);  // >= covers a mode switch past the limit

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (slot_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic                                  clk_i,
  input  logic                                  we_i,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] waddr_i,
  input  logic [DW-1:0]                         wdata_i,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] raddr_i,
  output logic [DW-1:0]                         rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/vdp_data_port.sv
module vdp_data_port
  import vdp_port_pkg::*;
#(
  parameter int VRAM_AW     = 12,
  parameter int CRAM_AW     = 6,
  parameter int VS_DEPTH    = 40,
  parameter int VS_DW       = 11,
  parameter int SLOT_WIDE   = 16,
  parameter int SLOT_NARROW = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_mode_i,
  input  logic        cmd_valid_i,
  input  logic [3:0]  cmd_code_i,
  input  logic [15:0] cmd_addr_i,
  input  logic [7:0]  incr_i,
  input  logic        wr_valid_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_valid_i,
  output logic        rd_ready_o,
  output logic [15:0] rd_data_o
);
  localparam int VW_AW       = VRAM_AW - 1;
  localparam int VW_DEPTH    = 2 ** VW_AW;
  localparam int CRAM_DEPTH  = 2 ** CRAM_AW;
  localparam int VS_IW       = $clog2(VS_DEPTH);
  localparam logic [VS_IW:0] VS_LIM = (VS_IW + 1)'(VS_DEPTH);

  logic [3:0]  code_q;
  logic [15:0] addr_q;
  logic [15:0] fifo_q;
  op_e         op;
  logic        slot;

  logic               wr_go, rd_go;
  logic [VW_AW-1:0]   vram_idx;
  logic [CRAM_AW-1:0] cram_idx;
  logic [VS_IW-1:0]   vs_idx;
  logic               vs_hit;
  logic [15:0]        vram_rd;
  logic [CRAM_DW-1:0] cram_rd;
  logic [VS_DW-1:0]   vs_rd;

  dp_code_dec u_dec (
    .code_i (code_q),
    .op_o   (op)
  );

  dp_slot_timer #(
    .WIDE   (SLOT_WIDE),
    .NARROW (SLOT_NARROW)
  ) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wide_i (wide_mode_i),
    .slot_o (slot)
  );

  assign vram_idx = addr_q[VRAM_AW-1:1];
  assign cram_idx = addr_q[CRAM_AW:1];
  assign vs_idx   = addr_q[VS_IW:1];
  assign vs_hit   = {1'b0, vs_idx} < VS_LIM;

  assign wr_go      = wr_valid_i & ~cmd_valid_i;
  assign rd_ready_o = rd_valid_i & ~cmd_valid_i & ~wr_valid_i &
                      ((op != OP_VRAM_RD16) | slot);
  assign rd_go      = rd_valid_i & rd_ready_o;

  dp_ram #(.DW(16), .DEPTH(VW_DEPTH)) u_vram (
    .clk_i   (clk_i),
    .we_i    (wr_go & (op == OP_VRAM_WR)),
    .waddr_i (vram_idx),
    .wdata_i (wr_data_i),
    .raddr_i (vram_idx),
    .rdata_o (vram_rd)
  );

  dp_ram #(.DW(CRAM_DW), .DEPTH(CRAM_DEPTH)) u_cram (
    .clk_i   (clk_i),
    .we_i    (wr_go & (op == OP_CRAM_WR)),
    .waddr_i (cram_idx),
    .wdata_i (cram_pack(wr_data_i)),
    .raddr_i (cram_idx),
    .rdata_o (cram_rd)
  );

  dp_ram #(.DW(VS_DW), .DEPTH(VS_DEPTH)) u_vsram (
    .clk_i   (clk_i),
    .we_i    (wr_go & (op == OP_VS_WR) & vs_hit),
    .waddr_i (vs_idx),
    .wdata_i (wr_data_i[VS_DW-1:0]),
    .raddr_i (vs_idx),
    .rdata_o (vs_rd)
  );

  always_comb begin
    unique case (op)
      OP_VRAM_RD16: rd_data_o = vram_rd;
      OP_VRAM_RD8:  rd_data_o = {fifo_q[15:8], addr_q[0] ? vram_rd[15:8] : vram_rd[7:0]};
      OP_CRAM_RD:   rd_data_o = cram_unpack(cram_rd) | (fifo_q & ~CRAM_MASK);
      OP_VS_RD:     rd_data_o = vs_hit ? {fifo_q[15:VS_DW], vs_rd} : fifo_q;
      default:      rd_data_o = fifo_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      addr_q <= '0;
      fifo_q <= '0;
    end else if (cmd_valid_i) begin
      code_q <= cmd_code_i;
      addr_q <= cmd_addr_i;
    end else if (wr_go) begin
      fifo_q <= wr_data_i;
      addr_q <= addr_q + 16'(incr_i);
    end else if (rd_go) begin
      addr_q <= addr_q + 16'(incr_i);
    end
  end
endmodule

// File: rtl/dp_port_checker.sv
module dp_port_checker
  import vdp_port_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [3:0]  cmd_code_i,
  input logic [15:0] cmd_addr_i,
  input logic [7:0]  incr_i,
  input logic        wr_valid_i,
  input logic [15:0] wr_data_i,
  input logic        rd_valid_i,
  input logic        rd_ready_o,
  input logic [15:0] rd_data_o,
  input logic        slot_i,
  input logic [3:0]  code_q_i,
  input logic [15:0] addr_q_i,
  input logic [15:0] fifo_q_i
);
  logic take_rd, noop_code;
  assign take_rd   = rd_valid_i & rd_ready_o;
  assign noop_code = (code_q_i[1:0] == 2'b10) || (code_q_i inside {4'h7, 4'h9, 4'hB, 4'hD, 4'hF});

  a_r1_cmd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (addr_q_i == $past(cmd_addr_i)) && (code_q_i == $past(cmd_code_i)));

  a_r3_rd16_on_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_rd && code_q_i == 4'h0) |-> slot_i);

  a_r3_slot_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> !slot_i);

  a_r5_cram_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_rd && code_q_i == 4'h8) |-> ((rd_data_o & ~CRAM_MASK) == (fifo_q_i & ~CRAM_MASK)));

  a_r7_noop_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_rd && noop_code) |-> (rd_data_o == fifo_q_i));

  a_r8_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && (wr_valid_i || take_rd)) |=> (addr_q_i == $past(addr_q_i) + 16'($past(incr_i))));

  a_r9_fifo_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !cmd_valid_i) |=> (fifo_q_i == $past(wr_data_i)));

  a_r10_ready_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i || wr_valid_i) |-> !rd_ready_o);
endmodule

bind vdp_data_port dp_port_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_code_i  (cmd_code_i),
  .cmd_addr_i  (cmd_addr_i),
  .incr_i      (incr_i),
  .wr_valid_i  (wr_valid_i),
  .wr_data_i   (wr_data_i),
  .rd_valid_i  (rd_valid_i),
  .rd_ready_o  (rd_ready_o),
  .rd_data_o   (rd_data_o),
  .slot_i      (slot),
  .code_q_i    (code_q),
  .addr_q_i    (addr_q),
  .fifo_q_i    (fifo_q)
);

// File: tb/vdp_data_port_tb.sv
module vdp_data_port_tb_top;
  localparam int VAW = 8;
  localparam int NB  = 1 << VAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  incr = 8'd0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  vdp_data_port #(.VRAM_AW(VAW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wide_mode_i (wide_mode),
    .cmd_valid_i (cmd_valid),
    .cmd_code_i  (cmd_code),
    .cmd_addr_i  (cmd_addr),
    .incr_i      (incr),
    .wr_valid_i  (wr_valid),
    .wr_data_i   (wr_data),
    .rd_valid_i  (rd_valid),
    .rd_ready_o  (rd_ready),
    .rd_data_o   (rd_data)
  );

  logic [7:0]  vm [NB];
  logic [15:0] cm [64];
  logic [10:0] vs [40];
  logic [15:0] fifo_m = '0;
  logic [15:0] addr_m = '0;
  logic [3:0]  code_m = '0;
  int checks = 0, errors = 0, cyc = 0, rdy_cyc = 0, waits = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    int bi = int'(addr_m[VAW-1:0]);
    int ci = int'(addr_m[6:1]);
    case (code_m)
      4'h0: return {vm[bi & ~1], vm[bi | 1]};
      4'hC: return {fifo_m[15:8], vm[bi ^ 1]};
      4'h8: return cm[ci] | (fifo_m & ~16'h0EEE);
      4'h4: return (ci < 40) ? {fifo_m[15:11], vs[ci]} : fifo_m;
      default: return fifo_m;
    endcase
  endfunction

  function automatic void model_wr(input logic [15:0] d);
    int bi = int'(addr_m[VAW-1:0]) & ~1;
    int ci = int'(addr_m[6:1]);
    case (code_m)
      4'h1: begin vm[bi] = d[15:8]; vm[bi | 1] = d[7:0]; end
      4'h3: cm[ci] = d & 16'h0EEE;
      4'h5: if (ci < 40) vs[ci] = d[10:0];
      default: ;
    endcase
    fifo_m = d;
    addr_m = addr_m + 16'(incr);
  endfunction

  task automatic cmd(input logic [3:0] c, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    code_m = c; addr_m = a;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_wr(d);
  endtask

  task automatic rd(input string req);
    logic [15:0] e = exp_rd();
    @(negedge clk);
    rd_valid = 1'b1;
    waits = 0;
    #1;
    while (!rd_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rdy_cyc = cyc;
    check(req, rd_data, e);
    @(negedge clk);
    rd_valid = 1'b0;
    addr_m = addr_m + 16'(incr);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state; held code 0 must wait for the first slot
    check("R1 ready idle", {15'b0, rd_ready}, 16'h0);
    rd_valid = 1'b1; #1;
    check("R1 R3 code0 no early ready", {15'b0, rd_ready}, 16'h0);
    @(negedge clk); rd_valid = 1'b0;
    cmd(4'h7, 16'h1234);
    rd("R1 last-write reset to zero");
    check("R7 noop read immediate", 16'(waits), 16'h0);

    // R2 R8: video RAM word sweep, wide mode
    incr = 8'd2;
    cmd(4'h1, 16'h0000);
    for (int i = 0; i < NB / 2; i++) wr(16'(i * 16'h0301) ^ 16'hA55A);
    cmd(4'h0, 16'h0000);
    prev = 0;
    for (int i = 0; i < NB / 2; i++) begin
      rd("R2 word read");
      if (i > 0) check("R3 wide slot gap", 16'(rdy_cyc - prev), 16'd16);
      prev = rdy_cyc;
    end

    // R3: narrow mode spacing
    wide_mode = 1'b0;
    cmd(4'h0, 16'h0040);
    for (int i = 0; i < 6; i++) begin
      rd("R3 narrow word read");
      if (i > 1) check("R3 narrow slot gap", 16'(rdy_cyc - prev), 16'd20);
      prev = rdy_cyc;
    end
    wide_mode = 1'b1;

    // R4: byte reads across every byte, R9 sets upper byte
    cmd(4'hC, 16'h0000);
    wr(16'hBEEF);
    incr = 8'd1;
    cmd(4'hC, 16'h0000);
    for (int i = 0; i < NB; i++) begin
      rd("R4 byte read");
      if (i == 0) check("R4 byte read no wait", 16'(waits), 16'h0);
    end

    // R8: address wraps modulo 2^16
    incr = 8'd4;
    cmd(4'h0, 16'hFFFE);
    rd("R8 read before wrap");
    rd("R8 read after wrap");

    // R5: colour RAM sweep and index wrap
    incr = 8'd2;
    cmd(4'h3, 16'h0000);
    for (int i = 0; i < 64; i++) wr(16'(i * 16'h0137) ^ 16'h5FFF);
    cmd(4'h8, 16'h0000);
    for (int i = 0; i < 64; i++) rd("R5 colour read");
    cmd(4'h8, 16'h0086);
    rd("R5 colour index wrap");

    // R6: vertical-scroll sweep incl. out-of-range indices
    cmd(4'h5, 16'h0000);
    for (int i = 0; i < 64; i++) wr(16'(i * 16'h0B05) ^ 16'hC3A1);
    cmd(4'h4, 16'h0000);
    for (int i = 0; i < 64; i++) rd("R6 vscroll read");

    // R7 R9: no-op codes and writes under read codes
    incr = 8'd0;
    foreach (vm[k]) if (k < 0) vm[k] = 8'h0;
    begin
      logic [3:0] nc [9] = '{4'h2, 4'h6, 4'h7, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
      for (int i = 0; i < 9; i++) begin
        cmd(nc[i], 16'h0010);
        wr(16'h1111 * 16'(i + 1));
        rd("R7 R9 noop returns last write");
      end
    end
    cmd(4'h0, 16'h0010); wr(16'hDEAD);
    cmd(4'h4, 16'h0010); wr(16'hDEAD);
    cmd(4'h8, 16'h0010); wr(16'hDEAD);
    cmd(4'hC, 16'h0010); wr(16'hDEAD);
    cmd(4'h0, 16'h0010); rd("R7 vram untouched");
    cmd(4'h8, 16'h0010); rd("R7 colour untouched");
    cmd(4'h4, 16'h0010); rd("R7 vscroll untouched");

    // R10: ready held low during write and command cycles
    cmd(4'h8, 16'h0000);
    @(negedge clk);
    rd_valid = 1'b1; wr_valid = 1'b1; wr_data = 16'h1357;
    #1 check("R10 ready low under write", {15'b0, rd_ready}, 16'h0);
    @(negedge clk);
    wr_valid = 1'b0;
    model_wr(16'h1357);
    cmd_valid = 1'b1; cmd_code = 4'h4; cmd_addr = 16'h0002;
    #1 check("R10 ready low under command", {15'b0, rd_ready}, 16'h0);
    @(negedge clk);
    cmd_valid = 1'b0; rd_valid = 1'b0;
    code_m = 4'h4; addr_m = 16'h0002;
    rd("R10 R9 data after blocked cycles");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule